// File: doc/BRIEF.md
# Host Memory Address Decoder with Remap

This block steers each physical address issued by a host processor to one of three targets. The targets are system DRAM, the memory-mapped I/O space, and a default downstream path that takes anything no local device claims. When the target is DRAM, the block also produces the address to send to the memory controller.

Below a programmable low boundary under 4GB, addresses reach DRAM unchanged. The span from that boundary up to 4GB is an I/O hole, and the DRAM behind it cannot be reached directly. That hidden DRAM is recovered through a remap window placed above 4GB. Hits in the window are folded back so they land just above the low boundary. The 640KB–1MB legacy window is split into 16KB segments. Each segment has a two-bit access attribute that can shadow firmware into DRAM or hand the access downstream.

The decode is purely combinational. The configuration inputs are expected to come from registers that stay stable while a request is presented.

Top module: `host_mem_decoder`

## Requirements
- R1: A valid address below 4GB that lies outside 0A0000–0FFFFF and below `cfgLowLimit` selects DRAM, and `dramAddr` equals the request address.
- R2: A valid address below 4GB that lies outside 0A0000–0FFFFF and at or above `cfgLowLimit` selects MMIO.
- R3: When `cfgRemapBase` <= `cfgRemapLimit`, an address in [`cfgRemapBase`, `cfgRemapLimit`] selects DRAM with `dramAddr` = `cfgLowLimit` + (address − `cfgRemapBase`). This check takes priority over R5.
- R4: When `cfgRemapLimit` < `cfgRemapBase`, remapping is off. Every address at or above 4GB is then decoded by R5 alone.
- R5: An address at or above 4GB that is not remapped selects DRAM with `dramAddr` equal to the address when it is below `cfgUpperLimit`. Otherwise it selects MMIO.
- R6: Attribute layout in `cfgShadowAttr` (byte n is bits [8n+7:8n]). Bits [5:4] of byte 0 govern 0F0000–0FFFFF. For k = 1..6, byte k bits [1:0] govern the 16KB segment at 0C0000 + (k−1)·0x8000, and byte k bits [5:4] govern the next 16KB segment. Codes: 00 disabled, 01 read-only, 10 write-only, 11 read-write.
- R7: A 0C0000–0FFFFF access that its segment attribute permits selects DRAM with an unchanged address. A disabled segment, or a direction the attribute forbids, selects the forward target.
- R8: Addresses 0A0000–0BFFFF always select the forward target, whatever the attributes.
- R9: `tgtSel` bit 0 is DRAM, bit 1 is MMIO and bit 2 is forward. Exactly one bit is set while `reqValid` is 1, and all bits are 0 while it is 0. `claimed` equals bit 0 OR bit 1.
- R10: `dramAddr` is zero whenever the DRAM target is not selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| reqValid | input | 1 | Request present |
| reqAddr | input | 36 | Physical request address |
| reqWrite | input | 1 | 1 = write, 0 = read |
| cfgLowLimit | input | 32 | Low DRAM boundary, below 4GB |
| cfgUpperLimit | input | 36 | Upper DRAM boundary, above 4GB |
| cfgRemapBase | input | 36 | First address of the remap window |
| cfgRemapLimit | input | 36 | Last address of the remap window |
| cfgShadowAttr | input | 56 | Legacy segment attributes, seven bytes |
| tgtSel | output | 3 | One-hot target: DRAM, MMIO, forward |
| dramAddr | output | 36 | Translated DRAM address |
| claimed | output | 1 | Claimed locally (DRAM or MMIO) |

## Verification
On every evaluation, the embedded assertions check that the target is one-hot or idle, and that the DRAM address is zero off the DRAM path. They also check that a reversed window never produces a remap hit, that the 0A0000–0BFFFF span always forwards, that a forbidden legacy access is never claimed, and that the hole below 4GB selects MMIO. The scenarios alone show the arithmetic of the remap fold at both window ends, the exact boundaries of the low and upper limits, and the segment-by-segment bit layout of the attributes for each direction.

// File: rtl/hmd_pkg.sv
package hmd_pkg;

  typedef enum logic [1:0] {
    ATTR_OFF = 2'b00,
    ATTR_RO  = 2'b01,
    ATTR_WO  = 2'b10,
    ATTR_RW  = 2'b11
  } shadowAttr_e;

  typedef struct packed {
    logic dramDirect;
    logic dramRemap;
    logic mmio;
    logic forward;
  } decStrobe_t;

  localparam int SEL_DRAM   = 0;
  localparam int SEL_MMIO   = 1;
  localparam int SEL_FWD    = 2;
  localparam int SEL_W      = 3;
  localparam int ATTR_BYTES = 7;
  localparam int SHADOW_W   = 8 * ATTR_BYTES;
  localparam int NUM_SEG    = 16;

endpackage

// File: rtl/hmd_ctrl.sv
module hmd_ctrl
  import hmd_pkg::*;
#(
  parameter int ADDR_W = 36,
  parameter int LOW_W  = 32
) (
  input  logic                reqValid,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic                reqWrite,
  input  logic [LOW_W-1:0]    cfgLowLimit,
  input  logic [ADDR_W-1:0]   cfgUpperLimit,
  input  logic [ADDR_W-1:0]   cfgRemapBase,
  input  logic [ADDR_W-1:0]   cfgRemapLimit,
  input  logic [SHADOW_W-1:0] cfgShadowAttr,
  output decStrobe_t          strobe
);

  localparam int HI_W = ADDR_W - LOW_W;

  logic below4g, inLegacy, inVga, remapOn, inWindow, permit, belowLow;
  logic [1:0] segAttr [NUM_SEG];
  shadowAttr_e curAttr;

  assign below4g  = (reqAddr[ADDR_W-1:LOW_W] == '0);
  assign inLegacy = below4g && (reqAddr[LOW_W-1:20] == '0) &&
                    ((reqAddr[19:18] == 2'b11) || (reqAddr[19:17] == 3'b101));
  assign inVga    = inLegacy && (reqAddr[19:17] == 3'b101);
  assign belowLow = reqAddr < {{HI_W{1'b0}}, cfgLowLimit};
  assign remapOn  = (cfgRemapBase <= cfgRemapLimit);
  assign inWindow = remapOn && (reqAddr >= cfgRemapBase) && (reqAddr <= cfgRemapLimit);

  for (genvar g = 0; g < NUM_SEG; g++) begin : gSeg
    if (g >= 12) begin : gTop
      assign segAttr[g] = cfgShadowAttr[5:4];
    end else begin : gLow
      assign segAttr[g] = cfgShadowAttr[(g/2 + 1)*8 + (g%2)*4 +: 2];
    end
  end

  assign curAttr = shadowAttr_e'(segAttr[reqAddr[17:14]]);

  always_comb begin
    unique case (curAttr)
      ATTR_RW: permit = 1'b1;
      ATTR_RO: permit = !reqWrite;
      ATTR_WO: permit = reqWrite;
      default: permit = 1'b0;
    endcase
  end

  always_comb begin
    strobe = '0;
    if (reqValid) begin
      if (below4g) begin
        if (inLegacy) begin
          if (inVga || !permit) strobe.forward    = 1'b1;
          else                  strobe.dramDirect = 1'b1;
        end else if (belowLow) begin
          strobe.dramDirect = 1'b1;
        end else begin
          strobe.mmio = 1'b1;
        end
      end else if (inWindow) begin
        strobe.dramRemap = 1'b1;
      end else if (reqAddr < cfgUpperLimit) begin
        strobe.dramDirect = 1'b1;
      end else begin
        strobe.mmio = 1'b1;
      end
    end
  end

  // Guards on the strobe decisions
  always_comb begin
    if (cfgRemapLimit < cfgRemapBase)
      a_r4_no_remap_when_off: assert (!strobe.dramRemap) else $error("R4 remap hit while off");
    if (reqValid && inVga)
      a_r8_vga_forwards: assert (strobe.forward) else $error("R8 legacy video span not forwarded");
    if (reqValid && inLegacy && !permit)
      a_r7_forbidden_not_claimed: assert (!strobe.dramDirect && !strobe.mmio)
        else $error("R7 forbidden legacy access claimed");
    if (reqValid && below4g && !inLegacy && !belowLow)
      a_r2_hole_is_mmio: assert (strobe.mmio) else $error("R2 hole not MMIO");
  end

endmodule

// File: rtl/hmd_datapath.sv
module hmd_datapath
  import hmd_pkg::*;
#(
  parameter int ADDR_W = 36,
  parameter int LOW_W  = 32
) (
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LOW_W-1:0]  cfgLowLimit,
  input  logic [ADDR_W-1:0] cfgRemapBase,
  input  decStrobe_t        strobe,
  output logic [SEL_W-1:0]  tgtSel,
  output logic [ADDR_W-1:0] dramAddr,
  output logic              claimed
);

  localparam int HI_W = ADDR_W - LOW_W;

  logic [ADDR_W-1:0] windowOffset, foldedAddr;

  assign windowOffset = reqAddr - cfgRemapBase;
  assign foldedAddr   = {{HI_W{1'b0}}, cfgLowLimit} + windowOffset;

  always_comb begin
    tgtSel           = '0;
    tgtSel[SEL_DRAM] = strobe.dramDirect | strobe.dramRemap;
    tgtSel[SEL_MMIO] = strobe.mmio;
    tgtSel[SEL_FWD]  = strobe.forward;
  end

  always_comb begin
    if (strobe.dramRemap)       dramAddr = foldedAddr;
    else if (strobe.dramDirect) dramAddr = reqAddr;
    else                        dramAddr = '0;
  end

  assign claimed = tgtSel[SEL_DRAM] | tgtSel[SEL_MMIO];

  // Guards on the output encoding
  always_comb begin
    if (reqValid)
      a_r9_one_target: assert ($countones(tgtSel) == 1) else $error("R9 target not one-hot");
    else
      a_r9_idle_quiet: assert (tgtSel == '0) else $error("R9 target while idle");
    if (!tgtSel[SEL_DRAM])
      a_r10_addr_zero: assert (dramAddr == '0) else $error("R10 DRAM address off DRAM path");
  end

endmodule

// File: rtl/host_mem_decoder.sv
module host_mem_decoder
  import hmd_pkg::*;
#(
  parameter int ADDR_W = 36,
  parameter int LOW_W  = 32
) (
  input  logic                reqValid,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic                reqWrite,
  input  logic [LOW_W-1:0]    cfgLowLimit,
  input  logic [ADDR_W-1:0]   cfgUpperLimit,
  input  logic [ADDR_W-1:0]   cfgRemapBase,
  input  logic [ADDR_W-1:0]   cfgRemapLimit,
  input  logic [SHADOW_W-1:0] cfgShadowAttr,
  output logic [SEL_W-1:0]    tgtSel,
  output logic [ADDR_W-1:0]   dramAddr,
  output logic                claimed
);

  decStrobe_t strobe;

  hmd_ctrl #(.ADDR_W(ADDR_W), .LOW_W(LOW_W)) uCtrl (
    .reqValid      (reqValid),
    .reqAddr       (reqAddr),
    .reqWrite      (reqWrite),
    .cfgLowLimit   (cfgLowLimit),
    .cfgUpperLimit (cfgUpperLimit),
    .cfgRemapBase  (cfgRemapBase),
    .cfgRemapLimit (cfgRemapLimit),
    .cfgShadowAttr (cfgShadowAttr),
    .strobe        (strobe)
  );

  hmd_datapath #(.ADDR_W(ADDR_W), .LOW_W(LOW_W)) uData (
    .reqValid     (reqValid),
    .reqAddr      (reqAddr),
    .cfgLowLimit  (cfgLowLimit),
    .cfgRemapBase (cfgRemapBase),
    .strobe       (strobe),
    .tgtSel       (tgtSel),
    .dramAddr     (dramAddr),
    .claimed      (claimed)
  );

endmodule

// File: tb/tb_host_mem_decoder.sv
`timescale 1ns/1ps
module tb_host_mem_decoder;

  logic        clk = 1'b0;
  logic        reqValid = 1'b0;
  logic [35:0] reqAddr = '0;
  logic        reqWrite = 1'b0;
  logic [31:0] cfgLowLimit = '0;
  logic [35:0] cfgUpperLimit = '0;
  logic [35:0] cfgRemapBase = '0;
  logic [35:0] cfgRemapLimit = '0;
  logic [55:0] cfgShadowAttr = '0;
  logic [2:0]  tgtSel;
  logic [35:0] dramAddr;
  logic        claimed;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    logic [2:0]  sel;
    logic [35:0] addr;
    string       req;
  } expItem_t;

  expItem_t sb[$];

  localparam logic [2:0] T_DRAM = 3'b001, T_MMIO = 3'b010, T_FWD = 3'b100, T_NONE = 3'b000;

  always #2.5 clk = ~clk;

  host_mem_decoder dut (
    .reqValid(reqValid), .reqAddr(reqAddr), .reqWrite(reqWrite),
    .cfgLowLimit(cfgLowLimit), .cfgUpperLimit(cfgUpperLimit),
    .cfgRemapBase(cfgRemapBase), .cfgRemapLimit(cfgRemapLimit),
    .cfgShadowAttr(cfgShadowAttr),
    .tgtSel(tgtSel), .dramAddr(dramAddr), .claimed(claimed)
  );

  task automatic apply(input logic v, input logic [35:0] a, input logic w,
                       input logic [2:0] sel, input logic [35:0] ea, input string req);
    expItem_t it;
    @(negedge clk);
    reqValid = v; reqAddr = a; reqWrite = w;
    it.sel = sel; it.addr = ea; it.req = req;
    sb.push_back(it);
  endtask

  // Monitor: compare at the rising edge, half a period after the inputs moved
  always @(posedge clk) begin
    if (sb.size() > 0) begin
      expItem_t it;
      it = sb.pop_front();
      checks++;
      if (tgtSel !== it.sel || dramAddr !== it.addr || claimed !== (it.sel[0] | it.sel[1])) begin
        fails++;
        $display("FAIL %s: sel=%b addr=%h claimed=%b expected sel=%b addr=%h claimed=%b",
                 it.req, tgtSel, dramAddr, claimed, it.sel, it.addr, it.sel[0] | it.sel[1]);
      end
    end
  end

  initial begin
    for (int i = 0; i < 5000 && !done; i++) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    cfgLowLimit   = 32'h8000_0000;
    cfgUpperLimit = 36'h1_C000_0000;
    cfgRemapBase  = 36'h1_4000_0000;
    cfgRemapLimit = 36'h1_BFFF_FFFF;
    cfgShadowAttr = '0;
    // idle state
    apply(0, 36'h0_0000_1000, 0, T_NONE, '0, "R9 idle");
    // R1 low DRAM
    apply(1, 36'h0_0000_1000, 0, T_DRAM, 36'h0_0000_1000, "R1 low");
    apply(1, 36'h0_7FFF_FFFF, 1, T_DRAM, 36'h0_7FFF_FFFF, "R1 last below limit");
    apply(1, 36'h0_0009_FFFF, 0, T_DRAM, 36'h0_0009_FFFF, "R1 below legacy");
    // R2 hole, R10 zero address
    apply(1, 36'h0_8000_0000, 0, T_MMIO, '0, "R2 R10 hole start");
    apply(1, 36'h0_FFFF_FFF0, 0, T_MMIO, '0, "R2 hole top");
    // R3 remap fold
    apply(1, 36'h1_4000_0000, 0, T_DRAM, 36'h0_8000_0000, "R3 window start");
    apply(1, 36'h1_BFFF_FFFF, 1, T_DRAM, 36'h0_FFFF_FFFF, "R3 window end");
    // R5 above 4GB
    apply(1, 36'h1_0000_0000, 0, T_DRAM, 36'h1_0000_0000, "R5 4GB");
    apply(1, 36'h1_3FFF_FFFF, 0, T_DRAM, 36'h1_3FFF_FFFF, "R5 below window");
    apply(1, 36'h1_C000_0000, 0, T_MMIO, '0, "R5 upper limit");
    // R7 disabled segment, R8 video span
    apply(1, 36'h0_000F_0000, 0, T_FWD, '0, "R7 disabled");
    apply(1, 36'h0_000A_0000, 0, T_FWD, '0, "R8 video");

    @(negedge clk);
    cfgShadowAttr = 56'h10_00_00_00_00_23_10;
    apply(1, 36'h0_000F_FFF0, 0, T_DRAM, 36'h0_000F_FFF0, "R6 R7 top seg read");
    apply(1, 36'h0_000F_0000, 1, T_FWD, '0, "R7 top seg write forbidden");
    apply(1, 36'h0_000C_0000, 1, T_DRAM, 36'h0_000C_0000, "R6 C0000 rw");
    apply(1, 36'h0_000C_4000, 0, T_FWD, '0, "R6 C4000 wo read");
    apply(1, 36'h0_000C_4000, 1, T_DRAM, 36'h0_000C_4000, "R6 C4000 wo write");
    apply(1, 36'h0_000E_C000, 0, T_DRAM, 36'h0_000E_C000, "R6 EC000 ro");
    apply(1, 36'h0_000E_BFFF, 0, T_FWD, '0, "R6 E8000 off");
    apply(1, 36'h0_000C_8000, 0, T_FWD, '0, "R6 C8000 off");

    @(negedge clk);
    cfgShadowAttr = '1;
    apply(1, 36'h0_000B_FFFF, 1, T_FWD, '0, "R8 video with rw");
    apply(1, 36'h0_000C_8000, 1, T_DRAM, 36'h0_000C_8000, "R6 C8000 rw");

    // R4 remap off
    @(negedge clk);
    cfgRemapLimit = '0;
    apply(1, 36'h1_4000_0000, 0, T_DRAM, 36'h1_4000_0000, "R4 off identity");
    @(negedge clk);
    cfgUpperLimit = 36'h1_4000_0000;
    apply(1, 36'h1_4000_0000, 0, T_MMIO, '0, "R4 off upper");
    apply(1, 36'h1_3FFF_FFFF, 0, T_DRAM, 36'h1_3FFF_FFFF, "R4 R5 below upper");
    apply(0, 36'h1_3FFF_FFFF, 0, T_NONE, '0, "R9 R10 idle end");

    while (sb.size() > 0) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule